// File: doc/BRIEF.md
# Unsigned Byte Matrix Tile Multiply-Accumulate Unit

This datapath unit takes three 128-bit vectors per operation: a left operand holding a 2x8 matrix of unsigned bytes, a right operand holding an 8x2 matrix of unsigned bytes, and an accumulator holding a 2x2 matrix of 32-bit lanes. It forms the 2x2 matrix product, where every element is an eight-term dot product of bytes, and adds it to the accumulator lanes. The 128-bit sum comes back as the result.

The unit sits in an execution pipeline behind a valid/ready handshake. It accepts one operation per cycle. All 32 byte multiplies run in parallel in the first stage. A second stage reduces each lane's eight products, and a third stage adds the accumulator. When the consumer withholds ready, every stage freezes.

Top module: `u8_tile_mac`

## Requirements
- R1: Left-operand byte k of row i (i in 0..1, k in 0..7) is read from bits [(8*i+k)*8+7 : (8*i+k)*8] of `in_a`.
- R2: Right-operand column j (j in 0..1) is read from bytes 8*j through 8*j+7 of `in_b`, with byte 8*j+k at bits [(8*j+k)*8+7 : (8*j+k)*8].
- R3: Result lane L = 2*i+j sits at bits [32*L+31 : 32*L] of `out_res`. It equals accumulator lane L (the same bits of `in_acc`) plus the sum over k of a(i,k)*b(k,j).
- R4: Every byte is treated as unsigned and zero-extended, so 0xFF times 0xFF contributes 65025.
- R5: The lane addition wraps modulo 2^32, with no saturation and no overflow indication. For example, all bytes 0xFF with lanes 0xFFFFFFFF give 0x0007F007 in every lane.
- R6: An operation accepted in one cycle appears on `out_valid` three cycles later when `out_ready` is held high. A new operation can be accepted every cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_res` hold steady. Every accepted operation is delivered exactly once, in order.
- R8: `in_ready` equals `out_ready` in every cycle, so a stall at the output halts the whole pipeline.
- R9: While and after reset (`rst_n` low, active low), `out_valid` is low until an operation has passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation taken this cycle when high with in_valid |
| in_a | input | 128 | Left operand, 2x8 unsigned bytes |
| in_b | input | 128 | Right operand, 8x2 unsigned bytes by column |
| in_acc | input | 128 | Four 32-bit accumulator lanes |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result; low stalls the pipeline |
| out_res | output | 128 | Four 32-bit result lanes |

## Verification
The checker assumes that `in_valid` is low throughout reset and that no operation is offered before the first clock edge. It also assumes that the operand buses carry known values whenever `in_valid` is high, because the no-unknown check on `out_res` depends on it. The bench drives `in_valid` low during reset and drives every operand bit with a defined value, both directed and random. It changes `out_ready` only between clock edges, so the latency and hold properties see clean handshakes while the random stall pattern is running.

// File: rtl/u8mac_pkg.sv
`timescale 1ns/1ps
package u8mac_pkg;
    localparam int unsigned ELEM_W = 8;   // operand element width
    localparam int unsigned ROWS   = 2;   // rows of the left matrix
    localparam int unsigned COLS   = 2;   // columns of the right matrix
    localparam int unsigned KDIM   = 8;   // inner dimension, power of two
    localparam int unsigned LANE_W = 32;  // accumulator lane width

    localparam int unsigned LANES  = ROWS * COLS;
    localparam int unsigned NPROD  = LANES * KDIM;
    localparam int unsigned PROD_W = 2 * ELEM_W;
    localparam int unsigned SUM_W  = PROD_W + $clog2(KDIM);
    localparam int unsigned A_W    = ROWS * KDIM * ELEM_W;
    localparam int unsigned B_W    = COLS * KDIM * ELEM_W;
    localparam int unsigned VEC_W  = LANES * LANE_W;

    typedef logic [PROD_W-1:0] prod_t;
    typedef logic [SUM_W-1:0]  sum_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic                   vld;
        prod_t [NPROD-1:0]      prod;
        lane_t [LANES-1:0]      acc;
    } mul_st_t;

    typedef struct packed {
        logic                   vld;
        sum_t  [LANES-1:0]      sum;
        lane_t [LANES-1:0]      acc;
    } red_st_t;

    typedef struct packed {
        logic                   vld;
        lane_t [LANES-1:0]      res;
    } acc_st_t;
endpackage

// File: rtl/u8mac_mul_stage.sv
`timescale 1ns/1ps
module u8mac_mul_stage
    import u8mac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic                     in_vld,
    input  logic [A_W-1:0]           in_a,
    input  logic [B_W-1:0]           in_b,
    input  lane_t [LANES-1:0]        in_acc,
    output mul_st_t                  st_q
);
    prod_t [NPROD-1:0] prod_w;
    mul_st_t           st_d;

    // One multiplier per (row, column, inner index) triple.
    for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
        for (genvar gj = 0; gj < COLS; gj++) begin : g_col
            for (genvar gk = 0; gk < KDIM; gk++) begin : g_k
                localparam int unsigned PIDX = (gi * COLS + gj) * KDIM + gk;
                localparam int unsigned AOFF = (gi * KDIM + gk) * ELEM_W;
                localparam int unsigned BOFF = (gj * KDIM + gk) * ELEM_W;
                assign prod_w[PIDX] = PROD_W'(in_a[AOFF +: ELEM_W])
                                    * PROD_W'(in_b[BOFF +: ELEM_W]);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.vld  = in_vld;
            st_d.prod = prod_w;
            st_d.acc  = in_acc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/u8mac_red_stage.sv
`timescale 1ns/1ps
module u8mac_red_stage
    import u8mac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    input  mul_st_t  up_q,
    output red_st_t  st_q
);
    red_st_t           st_d;
    sum_t [LANES-1:0]  sum_w;

    // Balanced pairwise reduction of KDIM products.
    function automatic sum_t tree_add(input prod_t [KDIM-1:0] p);
        sum_t t [KDIM];
        for (int k = 0; k < KDIM; k++) t[k] = sum_t'(p[k]);
        for (int w = KDIM / 2; w > 0; w = w / 2) begin
            for (int k = 0; k < w; k++) t[k] = t[2*k] + t[2*k+1];
        end
        return t[0];
    endfunction

    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        assign sum_w[gl] = tree_add(up_q.prod[gl*KDIM +: KDIM]);
    end

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.vld = up_q.vld;
            st_d.sum = sum_w;
            st_d.acc = up_q.acc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/u8mac_acc_stage.sv
`timescale 1ns/1ps
module u8mac_acc_stage
    import u8mac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    input  red_st_t  up_q,
    output acc_st_t  st_q
);
    acc_st_t st_d;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.vld = up_q.vld;
            for (int l = 0; l < LANES; l++) begin
                // Zero-extend the reduced sum; the add wraps at the lane width.
                st_d.res[l] = up_q.acc[l] + lane_t'(up_q.sum[l]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/u8_tile_mac.sv
`timescale 1ns/1ps
module u8_tile_mac
    import u8mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [A_W-1:0]   in_a,
    input  logic [B_W-1:0]   in_b,
    input  logic [VEC_W-1:0] in_acc,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_res
);
    logic    adv;
    mul_st_t mul_q;
    red_st_t red_q;
    acc_st_t acc_q;

    // Global stall: every stage advances together with the consumer.
    assign adv      = out_ready;
    assign in_ready = out_ready;

    u8mac_mul_stage mul_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .in_vld (in_valid),
        .in_a   (in_a),
        .in_b   (in_b),
        .in_acc (in_acc),
        .st_q   (mul_q)
    );

    u8mac_red_stage red_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .up_q  (mul_q),
        .st_q  (red_q)
    );

    u8mac_acc_stage acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .up_q  (red_q),
        .st_q  (acc_q)
    );

    assign out_valid = acc_q.vld;
    assign out_res   = acc_q.res;
endmodule

// File: rtl/u8mac_checker.sv
`timescale 1ns/1ps
module u8mac_checker
    import u8mac_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_res
);
    logic [1:0] since_rst_q;
    logic [2:0] inflight_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst_q <= '0;
            inflight_q  <= '0;
        end else begin
            if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
            inflight_q <= inflight_q + 3'(in_valid && in_ready)
                                     - 3'(out_valid && out_ready);
        end
    end

    // R6: accepted operation with two advancing cycles is visible after three edges
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3) && $past(in_valid && in_ready, 3)
        && $past(out_ready, 2) && $past(out_ready)
        |-> out_valid);

    // R7: a stalled result holds still
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_res));

    // R7: no result without a matching accepted operation
    a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight_q != 3'd0);

    // R7: never more operations in flight than pipeline stages
    a_r7_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= 3'd3);

    // R3: delivered lanes carry defined values
    a_r3_known_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_res));
endmodule

bind u8_tile_mac u8mac_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (out_res)
);

// File: tb/u8_tile_mac_tb_top.sv
`timescale 1ns/1ps
module u8_tile_mac_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_a, in_b, in_acc;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_res;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int sent   = 0;
    int recvd  = 0;
    bit stall_mode = 1'b0;

    logic [127:0] exp_q[$];
    int           cyc_q[$];
    bit           lat_q[$];
    string        tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    u8_tile_mac dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_acc    (in_acc),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_res   (out_res)
    );

    // Reference: lane 2i+j = acc + sum_k a[8i+k]*b[8j+k], unsigned, mod 2^32.
    function automatic logic [127:0] model(input logic [127:0] a, b, acc);
        logic [127:0] r;
        for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < 2; j++) begin
                logic [31:0] s;
                s = acc[32*(2*i+j) +: 32];
                for (int k = 0; k < 8; k++)
                    s = s + 32'(a[8*(8*i+k) +: 8]) * 32'(b[8*(8*j+k) +: 8]);
                r[32*(2*i+j) +: 32] = s;
            end
        end
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Driver: called at a falling edge; pushes the expected item on acceptance.
    task automatic send(input logic [127:0] a, b, acc, input string tag);
        in_a     = a;
        in_b     = b;
        in_acc   = acc;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        exp_q.push_back(model(a, b, acc));
        cyc_q.push_back(cyc);
        lat_q.push_back(!stall_mode);
        tag_q.push_back(tag);
        sent++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Consumer ready, changed just after each rising edge.
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    // Monitor / scoreboard
    initial begin
        bit           prev_stall = 1'b0;
        logic [127:0] held = '0;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1) begin
                check(in_ready === out_ready, "R8 in_ready tracks out_ready",
                      128'(in_ready), 128'(out_ready));
                if (prev_stall)
                    check(out_valid === 1'b1 && out_res === held,
                          "R7 stalled result held", out_res, held);
                prev_stall = out_valid && !out_ready;
                held       = out_res;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7 result with nothing outstanding",
                              out_res, '0);
                    end else begin
                        logic [127:0] e;
                        int           c;
                        bit           l;
                        string        t;
                        e = exp_q.pop_front();
                        c = cyc_q.pop_front();
                        l = lat_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_res === e, t, out_res, e);
                        if (l)
                            check(cyc == c + 3, "R6 three-cycle latency",
                                  128'(cyc - c), 128'(3));
                        recvd++;
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] a, b, acc;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_a     = '0;
        in_b     = '0;
        in_acc   = '0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R9 idle during reset", 128'(out_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R9 idle after reset", 128'(out_valid), '0);

        // Directed, back to back, no stalls
        send('0, '0, '0, "R3 all zero");
        a = '0; a[8*(8*1+5) +: 8] = 8'd3;
        send(a, {16{8'h01}}, '0, "R1 row1 byte5 placement");
        a = '0; a[8*(8*0+2) +: 8] = 8'd7;
        send(a, {16{8'h02}}, {32'd4, 32'd3, 32'd2, 32'd1}, "R1 row0 byte2 placement");
        b = '0; b[8*(8*1+7) +: 8] = 8'd9;
        send({16{8'h01}}, b, '0, "R2 column1 byte7 placement");
        b = '0; b[8*(8*0+0) +: 8] = 8'd5;
        send({16{8'h01}}, b, '0, "R2 column0 byte0 placement");
        send({16{8'hFF}}, {16{8'hFF}}, '0, "R4 unsigned 0xFF products");
        send({16{8'h80}}, {16{8'hFF}}, '0, "R4 high bit not a sign");
        send({16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_FFFF}}, "R5 wrap max accumulator");
        send({16{8'h01}}, {16{8'h01}}, {4{32'hFFFF_FFF9}}, "R5 wrap to exactly one");
        for (int n = 0; n < 20; n++) begin
            a = rnd128(); b = rnd128(); acc = rnd128();
            send(a, b, acc, "R3 random, one per cycle");
        end
        while (exp_q.size() != 0) @(negedge clk);

        // Random stalls and input gaps
        stall_mode = 1'b1;
        for (int n = 0; n < 60; n++) begin
            a = rnd128(); b = rnd128(); acc = rnd128();
            send(a, b, acc, "R7 random under stalls");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        send({16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_FFFF}}, "R5 wrap under stalls");
        stall_mode = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(sent == recvd, "R7 every operation delivered once",
              128'(recvd), 128'(sent));
        summary();
        $finish;
    end
endmodule